// File: doc/BRIEF.md
# Programmable Two-Digit Divide-by-N Down Counter

This block divides its clock by a programmable ratio N. It holds an 8-bit count as two 4-bit digits, a low digit and a high digit. Each digit counts down in decimal or in plain binary, and the choice is made for each digit separately. The high digit moves only when the low digit borrows. When the count reaches one, the next edge reloads the programmed value, so the count repeats with period N. A registered pulse, one cycle wide, marks each pass through the terminal state.

A feedback input sits at the cascade edge of the block. When it is held low, the reload is blocked. The count then runs through zero and wraps across the whole range of the two digits. The top bit of the high digit is brought out as a port, so the block can clock a further stage.

Top module: `divn_counter`

## Requirements
- R1: While the asynchronous active-low reset is asserted, both digits are zero and `zero_det_o` and `msb_o` are low.
- R2: Outside the terminal state, the low digit decreases by one on every rising clock edge. A low digit at zero wraps to 9 when its mode bit is 1 (decimal) and to 15 when the bit is 0 (binary).
- R3: The high digit changes only on an edge where the low digit wraps from zero. It follows the same wrap rule under its own mode bit.
- R4: `mode_bcd_i[0]` selects the mode of the low digit and `mode_bcd_i[1]` selects the mode of the high digit, independently. The ratio is N = hi*R_lo + lo, where R_lo is 10 in decimal mode and 16 in binary mode.
- R5: When the count is one and `cfb_i` is high, the next edge loads `preset_i[3:0]` into the low digit and `preset_i[7:4]` into the high digit. For N >= 2 this gives a period of exactly N cycles.
- R6: `zero_det_o` is high for exactly the one cycle after each cycle in which the count equals one, and low otherwise.
- R7: In decimal mode, a preset digit above 9 is loaded as 9.
- R8: While `cfb_i` is low, no reload happens and the count passes through zero and wraps. The `zero_det_o` period is then the full modulus: 256 in binary/binary, 100 in decimal/decimal, and 160 with a decimal low digit and a binary high digit.
- R9: `msb_o` is bit 3 of the high digit. With `preset_i[7]` low and `cfb_i` high, it stays low once the first reload has happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preset_i | input | 8 | Reload value; [3:0] low digit, [7:4] high digit |
| mode_bcd_i | input | 2 | Per-digit mode, 1 = decimal, 0 = binary; bit 0 low digit |
| cfb_i | input | 1 | Reload enable from the cascade, active high |
| zero_det_o | output | 1 | One-cycle terminal pulse |
| msb_o | output | 1 | Bit 3 of the high digit |

## Verification
A wrong digit value inside the counter shows at the ports in two ways. The `zero_det_o` pulse moves, and the period measured between pulses no longer equals N or the wrap modulus. A wrong high digit can also flip `msb_o` in the very next cycle. A fault in the borrow or wrap logic therefore shows up within at most one count period, which is never more than 256 cycles. A cycle-exact comparison of both outputs against an arithmetic model catches it at the first cycle where the pulse is early or late.

// File: rtl/divn_pkg.sv
package divn_pkg;
    localparam int DIG_W   = 4;
    localparam int NUM_STG = 2;

    typedef logic [DIG_W-1:0] digit_t;

    localparam digit_t DEC_TOP = digit_t'(9);
    localparam digit_t BIN_TOP = digit_t'(15);

    // Highest value a digit may hold in the given mode.
    function automatic digit_t digit_top(input logic bcd);
        return bcd ? DEC_TOP : BIN_TOP;
    endfunction

    // Limit a programmed digit to the valid range of its mode.
    function automatic digit_t digit_limit(input digit_t d, input logic bcd);
        return (bcd && (d > DEC_TOP)) ? DEC_TOP : d;
    endfunction
endpackage

// File: rtl/divn_stage.sv
module divn_stage
    import divn_pkg::*;
(
    input  digit_t cur_i,
    input  logic   bcd_i,
    input  digit_t preset_i,
    input  logic   load_i,
    input  logic   dec_i,
    output digit_t nxt_o,
    output logic   zero_o
);
    always_comb begin
        zero_o = (cur_i == '0);
        if (load_i) begin
            nxt_o = digit_limit(preset_i, bcd_i);
        end else if (dec_i) begin
            nxt_o = zero_o ? digit_top(bcd_i) : cur_i - digit_t'(1);
        end else begin
            nxt_o = cur_i;
        end
    end
endmodule

// File: rtl/divn_term.sv
module divn_term
    import divn_pkg::*;
#(
    parameter int STAGES = NUM_STG
) (
    input  logic [STAGES-1:0][DIG_W-1:0] stg_i,
    output logic                         is_one_o
);
    always_comb begin
        is_one_o = (stg_i[0] == digit_t'(1));
        for (int i = 1; i < STAGES; i++) begin
            if (stg_i[i] != '0) is_one_o = 1'b0;
        end
    end
endmodule

// File: rtl/divn_counter.sv
module divn_counter
    import divn_pkg::*;
#(
    parameter int STAGES = NUM_STG,
    localparam int PW    = STAGES * DIG_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [PW-1:0] preset_i,
    input  logic [STAGES-1:0] mode_bcd_i,
    input  logic          cfb_i,
    output logic          zero_det_o,
    output logic          msb_o
);
    typedef struct packed {
        logic [STAGES-1:0][DIG_W-1:0] stg;
        logic                         zd;
    } state_t;

    state_t st_d, st_q;

    logic [STAGES-1:0][DIG_W-1:0] stg_nxt;
    logic [STAGES-1:0]            stg_zero;
    logic [STAGES:0]              dec_chain;
    logic                         is_one;
    logic                         load;

    divn_term #(.STAGES(STAGES)) u_term (
        .stg_i    (st_q.stg),
        .is_one_o (is_one)
    );

    assign load         = is_one & cfb_i;
    assign dec_chain[0] = 1'b1;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        divn_stage u_stage (
            .cur_i    (st_q.stg[g]),
            .bcd_i    (mode_bcd_i[g]),
            .preset_i (preset_i[g*DIG_W +: DIG_W]),
            .load_i   (load),
            .dec_i    (dec_chain[g]),
            .nxt_o    (stg_nxt[g]),
            .zero_o   (stg_zero[g])
        );
        assign dec_chain[g+1] = dec_chain[g] & stg_zero[g];
    end

    always_comb begin
        st_d     = st_q;
        st_d.stg = stg_nxt;
        st_d.zd  = is_one;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign zero_det_o = st_q.zd;
    assign msb_o      = st_q.stg[STAGES-1][DIG_W-1];

    // R2
    lo_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!is_one && st_q.stg[0] != '0) |=> st_q.stg[0] == digit_t'($past(st_q.stg[0]) - digit_t'(1)));

    // R3
    hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!is_one && st_q.stg[0] != '0) |=> $stable(st_q.stg[STAGES-1:1]));

    // R6
    zd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_one |=> zero_det_o);

    // R6
    zd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !is_one |=> !zero_det_o);

    // R7
    lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_one && cfb_i && mode_bcd_i[0]) |=>
        st_q.stg[0] == (($past(preset_i[DIG_W-1:0]) > DEC_TOP) ? DEC_TOP : $past(preset_i[DIG_W-1:0])));

    // R8
    inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_one && !cfb_i) |=> (st_q.stg[0] == '0 && st_q.stg[STAGES-1:1] == '0));
endmodule

// File: tb/divn_counter_bench.sv
module divn_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] preset = 8'h00;
    logic [1:0] mode = 2'b00;
    logic       cfb = 1'b1;
    logic       zd, msb;

    int n_chk = 0;
    int n_bad = 0;
    int m_cnt = 0;
    int m_zd  = 0;

    always #10 clk = ~clk;

    divn_counter u_divn_counter (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .preset_i   (preset),
        .mode_bcd_i (mode),
        .cfb_i      (cfb),
        .zero_det_o (zd),
        .msb_o      (msb)
    );

    function automatic int rad(input logic bcd);
        return bcd ? 10 : 16;
    endfunction

    function automatic int lim(input int d, input logic bcd);
        return (bcd && d > 9) ? 9 : d;
    endfunction

    // Arithmetic reference: the count as a single integer in mixed radix.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0;
            m_zd  <= 0;
        end else begin
            int rl, modv;
            rl   = rad(mode[0]);
            modv = rl * rad(mode[1]);
            m_zd <= (m_cnt == 1) ? 1 : 0;
            if (m_cnt == 1 && cfb)
                m_cnt <= lim(int'(preset[7:4]), mode[1]) * rl + lim(int'(preset[3:0]), mode[0]);
            else
                m_cnt <= (m_cnt + modv - 1) % modv;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_phase(input logic [7:0] p, input logic [1:0] md, input logic fb,
                             input int cycles, input int exp_gap, input string tag);
        int last = -1;
        int gap  = -1;
        @(negedge clk);
        rst_n  = 1'b0;
        preset = p;
        mode   = md;
        cfb    = fb;
        @(negedge clk);
        check("R1 zero_det in reset", int'(zd), 0);
        check("R1 msb in reset", int'(msb), 0);
        rst_n = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check({tag, " zero_det"}, int'(zd), m_zd);
            check({tag, " R9 msb"}, int'(msb), ((m_cnt / rad(mode[0])) >> 3) & 1);
            if (zd) begin
                if (last >= 0) gap = c - last;
                last = c;
            end
        end
        check({tag, " R6 period"}, gap, exp_gap);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        run_phase(8'h25, 2'b00, 1'b1, 600, 37, "R2 R5 binary");
        run_phase(8'h47, 2'b11, 1'b1, 600, 47, "R4 decimal");
        run_phase(8'h93, 2'b01, 1'b1, 600, 93, "R3 R4 mixed");
        run_phase(8'h2C, 2'b11, 1'b1, 600, 29, "R7 clamp");
        run_phase(8'h85, 2'b00, 1'b1, 600, 133, "R9 msb binary");
        run_phase(8'h85, 2'b11, 1'b1, 600, 85, "R9 msb decimal");
        run_phase(8'h02, 2'b00, 1'b1, 400, 2, "R5 ratio two");
        run_phase(8'h25, 2'b00, 1'b0, 800, 256, "R8 inhibit binary");
        run_phase(8'h47, 2'b11, 1'b0, 800, 100, "R8 inhibit decimal");
        run_phase(8'h47, 2'b01, 1'b0, 800, 160, "R8 inhibit mixed");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule